// File: doc/BRIEF.md
# TDM transmit time-slot multiplexer

This block drives one serial time-division-multiplexed line from per-channel transmit data. A table of slot descriptors decides what each bit time carries. Each descriptor has four fields: a valid flag, a last-slot flag, a 6-bit channel pointer and an 8-bit bit-enable mask. When a bit position is enabled in a valid slot, the block raises a one-bit data request toward the channel that the pointer names. The channel answers in the same cycle with a ready strobe and the bit. Every other position drives the idle level 1 and fetches nothing. This lets several devices share the line, and it lets one 8-bit slot be split into subchannels.

A bit-time strobe paces the block. A frame sync that arrives with a strobe starts the frame at descriptor 0, bit 0. After the 8th bit of a descriptor marked last, the line rests high until the next frame sync. A host loads the table through a simple write port. An output-enable tells an external driver when the block owns the line. Protocol framing, buffer handling and pad control belong to the neighbouring logic.

Top module: `tdmtx_mux`

## Requirements
- R1: After reset, tx_out is 1, tx_oe is 0, underrun is 0, and req_valid stays 0 on every bit strobe until a bit strobe arrives with fsync high.
- R2: A cycle with tbl_we high stores tbl_wdata into descriptor tbl_addr. The descriptor layout is bit 15 valid, bit 14 last-slot, bits 13:8 channel pointer, bits 7:0 mask.
- R3: A bit strobe with fsync high handles descriptor 0, bit 0. tx_out, tx_oe and underrun change only on the clock edge that samples bit_en high, are visible the cycle after it, and hold until the next strobe.
- R4: In a slot whose valid bit is 0, all 8 bit times drive tx_out=1 and tx_oe=0 with no request.
- R5: In a valid slot, bit time k (k=0 first, MSB-first order) uses mask bit 7-k. If that mask bit is 1, req_valid is high during the strobe with req_chan equal to the pointer, and if req_ready is high the line then carries req_data with tx_oe=1.
- R6: In a valid slot, a bit time whose mask bit is 0 drives tx_out=1 with tx_oe=1 and raises no request.
- R7: If req_valid is high and req_ready is low during the strobe, that bit time drives tx_out=1, tx_oe=1 and underrun=1. Otherwise underrun is 0.
- R8: While req_valid is high, req_addr equals the channel pointer in bits 11:6, with bits 5:0 zero.
- R9: After the 8th bit of a descriptor whose last-slot bit is 1, each bit time drives tx_out=1 and tx_oe=0 with no request until a strobe arrives with fsync high.
- R10: A strobe with fsync high in the middle of a frame abandons the current position and handles descriptor 0, bit 0.
- R11: After the 8th bit of a descriptor whose last-slot bit is 0, sequencing moves to the next descriptor. After descriptor 31 it continues at descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_addr | input | 5 | Descriptor index to write |
| tbl_wdata | input | 16 | Descriptor value |
| bit_en | input | 1 | One-cycle strobe per line bit time |
| fsync | input | 1 | Frame sync, qualified by bit_en |
| req_valid | output | 1 | Bit request to the channel side |
| req_chan | output | 6 | Channel pointer of the request |
| req_addr | output | 12 | Channel parameter base address |
| req_ready | input | 1 | Channel supplies a bit this strobe |
| req_data | input | 1 | Bit supplied by the channel |
| tx_out | output | 1 | Serial line data |
| tx_oe | output | 1 | Line drive enable |
| underrun | output | 1 | Requested bit was not supplied |

## Verification
Requests are combinational, so req_valid, req_chan and req_addr are judged during the strobe cycle itself, after the inputs have settled. Line results pass through one register and are due in the cycle after the strobe. The driver pushes each bit's expected triple onto a queue. The monitor pops it on the falling edge after the strobe edge, and in every idle cycle between strobes it checks that the last value is still held.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;
  localparam int PTR_W   = 6;
  localparam int MASK_W  = 8;
  localparam int ENT_W   = 2 + PTR_W + MASK_W;
  localparam int BIT_W   = $clog2(MASK_W);
  localparam int BASE_W  = 12;
  localparam int BASE_LO = BASE_W - PTR_W;

  typedef struct packed {
    logic              vld;
    logic              wrp;
    logic [PTR_W-1:0]  ptr;
    logic [MASK_W-1:0] mask;
  } slot_ent_t;
endpackage

// File: rtl/tdmtx_rst_sync.sv
module tdmtx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/tdmtx_table.sv
module tdmtx_table
  import tdmtx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output slot_ent_t        rd_ent
);
  logic [ENT_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic             ce;
    logic [ENT_W-1:0] q;

    assign ce = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ce) begin
        q <= wr_data;
      end
    end

    assign mem[g] = q;
  end

  assign rd_ent = slot_ent_t'(mem[rd_addr]);

  // R2
  table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/tdmtx_seq.sv
module tdmtx_seq
  import tdmtx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic             cur_wrap,
  output logic             cur_act,
  output logic [AW-1:0]    cur_idx,
  output logic [BIT_W-1:0] cur_bit
);
  logic             run_q,  run_d;
  logic [AW-1:0]    idx_q,  idx_d;
  logic [BIT_W-1:0] bit_q,  bit_d;
  logic             start;
  logic             last_bit;

  always_comb begin
    start    = bit_en && fsync;
    cur_act  = start || run_q;
    cur_idx  = start ? '0 : idx_q;
    cur_bit  = start ? '0 : bit_q;
    last_bit = (cur_bit == BIT_W'(MASK_W - 1));

    run_d = run_q;
    idx_d = idx_q;
    bit_d = bit_q;
    if (bit_en && cur_act) begin
      if (last_bit) begin
        bit_d = '0;
        if (cur_wrap) begin
          run_d = 1'b0;
          idx_d = '0;
        end else begin
          run_d = 1'b1;
          idx_d = (cur_idx == AW'(DEPTH - 1)) ? '0 : AW'(cur_idx + 1'b1);
        end
      end else begin
        run_d = 1'b1;
        idx_d = cur_idx;
        bit_d = BIT_W'(cur_bit + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
      bit_q <= '0;
    end else if (bit_en) begin
      run_q <= run_d;
      idx_q <= idx_d;
      bit_q <= bit_d;
    end
  end

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync |=> run_q && (idx_q == '0) && (bit_q == BIT_W'(1)));

  // R9
  wrap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && cur_act && last_bit && cur_wrap |=> !run_q);

  // R11
  table_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && cur_act && last_bit && !cur_wrap && (cur_idx == AW'(DEPTH - 1))
    |=> run_q && (idx_q == '0));
endmodule

// File: rtl/tdmtx_bitgen.sv
module tdmtx_bitgen
  import tdmtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cur_act,
  input  slot_ent_t         ent,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic              req_ready,
  input  logic              req_data,
  output logic              req_valid,
  output logic [PTR_W-1:0]  req_chan,
  output logic [BASE_W-1:0] req_addr,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              underrun
);
  logic [BIT_W-1:0] mpos;
  logic             bit_used;
  logic             out_d, oe_d, und_d;

  always_comb begin
    mpos      = BIT_W'(MASK_W - 1) - cur_bit;
    bit_used  = cur_act && ent.vld && ent.mask[mpos];
    req_valid = bit_en && bit_used;
    req_chan  = ent.ptr;
    req_addr  = {ent.ptr, {BASE_LO{1'b0}}};

    out_d = 1'b1;
    oe_d  = 1'b0;
    und_d = 1'b0;
    if (cur_act && ent.vld) begin
      oe_d = 1'b1;
      if (bit_used) begin
        if (req_ready) begin
          out_d = req_data;
        end else begin
          und_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_out   <= 1'b1;
      tx_oe    <= 1'b0;
      underrun <= 1'b0;
    end else if (bit_en) begin
      tx_out   <= out_d;
      tx_oe    <= oe_d;
      underrun <= und_d;
    end
  end

  // R7
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> underrun && tx_out && tx_oe);

  // R5
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (tx_out == $past(req_data)) && tx_oe && !underrun);

  // R4
  release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> tx_out && !underrun);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_out) && $stable(tx_oe) && $stable(underrun));
endmodule

// File: rtl/tdmtx_mux.sv
module tdmtx_mux
  import tdmtx_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int AW = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [ENT_W-1:0]  tbl_wdata,
  input  logic              bit_en,
  input  logic              fsync,
  output logic              req_valid,
  output logic [PTR_W-1:0]  req_chan,
  output logic [BASE_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              req_data,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              underrun
);
  logic             rst_sync_n;
  logic             cur_act;
  logic [AW-1:0]    cur_idx;
  logic [BIT_W-1:0] cur_bit;
  slot_ent_t        cur_ent;

  tdmtx_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  tdmtx_table #(.DEPTH(NUM_SLOTS)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (cur_idx),
    .rd_ent  (cur_ent)
  );

  tdmtx_seq #(.DEPTH(NUM_SLOTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (bit_en),
    .fsync    (fsync),
    .cur_wrap (cur_ent.wrp),
    .cur_act  (cur_act),
    .cur_idx  (cur_idx),
    .cur_bit  (cur_bit)
  );

  tdmtx_bitgen u_bitgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_en    (bit_en),
    .cur_act   (cur_act),
    .ent       (cur_ent),
    .cur_bit   (cur_bit),
    .req_ready (req_ready),
    .req_data  (req_data),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .req_addr  (req_addr),
    .tx_out    (tx_out),
    .tx_oe     (tx_oe),
    .underrun  (underrun)
  );

  // R5
  req_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |-> bit_en);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cur_act |-> !req_valid);
endmodule

// File: tb/tdmtx_mux_tb.sv
module tdmtx_mux_tb;
  localparam int CLK_NS = 20;
  localparam int NSLOT  = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [4:0]  tbl_addr;
  logic [15:0] tbl_wdata;
  logic        bit_en, fsync, req_ready, req_data;
  logic        req_valid, tx_out, tx_oe, underrun;
  logic [5:0]  req_chan;
  logic [11:0] req_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] mirror [NSLOT];
  bit       m_run = 1'b0;
  int       m_idx = 0;
  int       m_bit = 0;

  logic [2:0] exp_q [$];
  string      tag_q [$];
  logic [2:0] exp_last;
  string      tag_last;
  bit         mon_on = 1'b0;
  logic       pend = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tdmtx_mux u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .bit_en(bit_en), .fsync(fsync),
    .req_valid(req_valid), .req_chan(req_chan), .req_addr(req_addr),
    .req_ready(req_ready), .req_data(req_data), .tx_out(tx_out),
    .tx_oe(tx_oe), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) pend <= bit_en;

  // monitor: pops one expected triple per strobe, checks hold between strobes
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected result", 0, 1);
        end else begin
          exp_last = exp_q.pop_front();
          tag_last = tag_q.pop_front();
          chk({tx_out, tx_oe, underrun} == exp_last, tag_last,
              {tx_out, tx_oe, underrun}, exp_last);
        end
      end else begin
        chk({tx_out, tx_oe, underrun} == exp_last, "R3 hold",
            {tx_out, tx_oe, underrun}, exp_last);
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 5'(a); tbl_wdata = d;
    mirror[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic bit_time(input logic fs, input logic rdy, input logic dat);
    logic [15:0] e;
    logic        rq;
    logic [2:0]  ex;
    string       tg;
    @(negedge clk);
    bit_en = 1'b1; fsync = fs; req_ready = rdy; req_data = dat;
    if (fs) begin m_run = 1'b1; m_idx = 0; m_bit = 0; end
    rq = 1'b0;
    e  = mirror[m_idx];
    if (!m_run) begin
      ex = 3'b100; tg = "R9 idle/R1";
    end else if (!e[15]) begin
      ex = 3'b100; tg = "R4 invalid slot";
    end else if (!e[7 - m_bit]) begin
      ex = 3'b110; tg = "R6 masked bit";
    end else begin
      rq = 1'b1;
      if (rdy) begin ex = {dat, 2'b10}; tg = "R5 data bit (R2 table)"; end
      else     begin ex = 3'b111;       tg = "R7 underrun"; end
    end
    #1;
    chk(req_valid == rq, fs ? "R10 R5 request" : "R5 request", req_valid, rq);
    if (rq) begin
      chk(req_chan == e[13:8], "R5 R11 channel", req_chan, e[13:8]);
      chk(req_addr == {e[13:8], 6'b0}, "R8 base addr", req_addr, {e[13:8], 6'b0});
    end
    exp_q.push_back(ex);
    tag_q.push_back(tg);
    if (m_run) begin
      if (m_bit == 7) begin
        m_bit = 0;
        if (e[14]) m_run = 1'b0;
        else       m_idx = (m_idx + 1) % NSLOT;
      end else begin
        m_bit++;
      end
    end
    @(negedge clk);
    bit_en = 1'b0; fsync = 1'b0; req_ready = 1'b0; req_data = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) mirror[i] = 16'h0;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    bit_en = 1'b0; fsync = 1'b0; req_ready = 1'b0; req_data = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_out == 1'b1, "R1 reset tx_out", tx_out, 1);
    chk(tx_oe == 1'b0, "R1 reset tx_oe", tx_oe, 0);
    chk(underrun == 1'b0, "R1 reset underrun", underrun, 0);
    chk(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
    exp_last = 3'b100; tag_last = "R1";
    mon_on = 1'b1;

    // R2 load a small frame: full, invalid, split, last with underrun
    wr(0, {1'b1, 1'b0, 6'd5,  8'hFF});
    wr(1, {1'b0, 1'b0, 6'd9,  8'hFF});
    wr(2, {1'b1, 1'b0, 6'h2A, 8'hA5});
    wr(3, {1'b1, 1'b1, 6'h11, 8'hFF});

    // R1 no requests before the first frame sync
    for (int k = 0; k < 5; k++) bit_time(1'b0, 1'b1, 1'b0);

    // R3 frame start, R4/R5/R6/R7 within
    for (int k = 0; k < 32; k++)
      bit_time(k == 0, k != 27, 1'(k ^ (k >> 2)));
    // R9 idle after last slot
    for (int k = 0; k < 6; k++) bit_time(1'b0, 1'b1, 1'b0);

    // R10 restart in mid frame
    for (int k = 0; k < 12; k++) bit_time(k == 0, 1'b1, 1'(k >> 1));
    for (int k = 0; k < 10; k++) bit_time(k == 0, 1'b1, 1'(~k));

    // R11 run through all descriptors without a last slot and roll over
    for (int i = 0; i < NSLOT; i++)
      wr(i, {1'b1, 1'b0, 6'(i + 3),
             (i == NSLOT - 1) ? 8'h01 : ((i == 0) ? 8'h80 : ((i == 7) ? 8'h18 : 8'h00))});
    for (int k = 0; k < NSLOT * 8 + 9; k++)
      bit_time(k == 0, 1'b1, 1'(k >> 3));

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 pending results", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule